// File: doc/BRIEF.md
# Multi-mode 8-bit PWM timer

This block is an 8-bit counter with two compare channels. Each channel drives one waveform output and owns one sticky flag. A third sticky flag marks overflow. A 3-bit mode field selects how the counter runs:

- free-running count;
- clear-on-compare, with the period set by compare register A;
- single-slope (fast) PWM;
- dual-slope (phase-correct) PWM.

In both PWM styles the top of the count is either the full-scale value or compare register A. A shared prescaler makes the count tick on every cycle, or on every 8, 64, 256 or 1024 cycles, or stops it.

Software-style access goes through one register port. It has a write strobe, an address, write data and registered read data. Through it a user loads the count, the two compare values, the mode and clock select, and the output setup. The user reads the flags through the same port and clears them by writing ones.

In the PWM modes the compare values are double-buffered. A written value becomes active only at a period boundary. In the other modes a write takes effect at once.

Top module: `pwm_timer8`

## Requirements
- R1: Register addresses are: 0 control (bits 2:0 mode, bits 5:3 clock select); 1 output setup (bits 1:0 channel A setting, bits 3:2 channel B setting); 2 count; 3 compare A; 4 compare B; 5 flags (bit 0 overflow, bit 1 compare A, bit 2 compare B). Mode codes are: 0 normal, 1 dual-slope with top 0xFF, 2 clear-on-compare with top = compare A, 3 single-slope with top 0xFF, 5 dual-slope with top = compare A, 7 single-slope with top = compare A. Codes 4 and 6 behave as normal.
- R2: A divider runs free from reset and advances by one each clock. Clock select 1 ticks every cycle. Selects 2, 3, 4 and 5 tick when the low 3, 6, 8 or 10 divider bits are all ones, which gives 1/8, 1/64, 1/256 and 1/1024 of the clock rate. Selects 0, 6 and 7 tick never, and the count then holds.
- R3: In normal mode each tick adds one and 0xFF wraps to 0x00. The overflow flag sets on the tick that steps the count from 0xFF to 0x00.
- R4: In clear-on-compare mode the count goes to 0 on the tick after it equals compare A. A compare write takes effect at once. If compare A is written below the current count, the count runs to 0xFF and wraps before the next match. Overflow sets on the step from 0xFF to 0x00.
- R5: In single-slope mode the count goes to 0 on the tick after TOP. Overflow sets on the TOP tick. Compare writes are held in a buffer and become active at that TOP tick. Setting 2 sets the output at the wrap and clears it on match. Setting 3 does the opposite. A wrap and a match on the same tick resolve to the wrap level.
- R6: In single-slope mode with setting 2 and TOP 0xFF, a compare value of 0 gives a high pulse one tick wide each period. A compare value of 0xFF gives a constant high level.
- R7: In dual-slope mode the count rises to TOP, holds TOP for one tick, then falls to 0. It holds 0 for one tick, then rises again. Overflow sets on the tick the count holds 0 while falling. Buffered compare values load on the TOP tick. Setting 2 clears the output on a match while rising and sets it on a match while falling. Setting 3 does the opposite.
- R8: Setting 0 drives the output low. In normal and clear-on-compare modes, settings 1, 2 and 3 toggle, clear and set the output on match. In the PWM modes, setting 1 toggles output A on match only when mode bit 2 is set. Otherwise setting 1 drives the output low, and output B always gets low.
- R9: A compare flag sets after every tick on which the count equals that channel's active compare value, in every mode.
- R10: Flags stay set until a write of 1 to their bit at address 5. Writing 0 has no effect. A set and a clear in the same cycle leave the flag set.
- R11: After reset all registers, outputs and flags are 0. A count write replaces the count at that edge. Read data shows the addressed register one clock after the address is presented. Outputs and flags change at the edge that ends the triggering tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Registered read data |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| flag_ovf | output | 1 | Sticky overflow flag |
| flag_cmpa | output | 1 | Sticky compare A flag |
| flag_cmpb | output | 1 | Sticky compare B flag |

## Verification
The bench builds the timer with the default 8-bit count. With that width, a full single-slope period takes 256 ticks and a full dual-slope period at TOP 0xFF takes 510 ticks. Both fit in a few thousand clocks at the undivided rate, so wrap, turnaround and buffer-load instants each occur many times per mode. The same width lets the slowest divider (1/1024) produce several ticks in a short run. The extreme compare values 0 and 0xFF coincide with the bottom and the top of the count, which brings the spike and constant-level cases within reach.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam logic [2:0] ADR_CTRL = 3'd0;
  localparam logic [2:0] ADR_OUTS = 3'd1;
  localparam logic [2:0] ADR_CNT  = 3'd2;
  localparam logic [2:0] ADR_CMPA = 3'd3;
  localparam logic [2:0] ADR_CMPB = 3'd4;
  localparam logic [2:0] ADR_FLAG = 3'd5;

  typedef enum logic [1:0] {
    OUT_OFF = 2'd0,
    OUT_TOG = 2'd1,
    OUT_CLR = 2'd2,
    OUT_SET = 2'd3
  } out_sel_e;

  function automatic logic is_fast(input logic [2:0] m);
    return (m == 3'd3) || (m == 3'd7);
  endfunction

  function automatic logic is_phase(input logic [2:0] m);
    return (m == 3'd1) || (m == 3'd5);
  endfunction

  function automatic logic is_ctc(input logic [2:0] m);
    return m == 3'd2;
  endfunction

  function automatic logic top_from_a(input logic [2:0] m);
    return (m == 3'd2) || (m == 3'd5) || (m == 3'd7);
  endfunction
endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
  parameter int LOG_MAX = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  localparam int SH1 = 3;
  localparam int SH2 = 6;
  localparam int SH3 = 8;

  logic [LOG_MAX-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + {{(LOG_MAX-1){1'b0}}, 1'b1};
  end

  always_comb begin
    case (sel_i)
      3'd1:    tick_o = 1'b1;
      3'd2:    tick_o = &pre_q[SH1-1:0];
      3'd3:    tick_o = &pre_q[SH2-1:0];
      3'd4:    tick_o = &pre_q[SH3-1:0];
      3'd5:    tick_o = &pre_q;
      default: tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter import ptmr_pkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] top_a_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o,
  output logic             wrap_o,
  output logic             ptop_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_nxt, top;
  logic             up_q, up_nxt, at_top, at_bot, fast, ph;

  assign fast   = is_fast(mode_i);
  assign ph     = is_phase(mode_i);
  assign top    = top_from_a(mode_i) ? top_a_i : '1;
  assign at_top = (cnt_q == top);
  assign at_bot = (cnt_q == '0);

  always_comb begin
    cnt_nxt = cnt_q + ONE;
    up_nxt  = up_q;
    if (ph) begin
      if (up_q) begin
        if (at_top) begin
          up_nxt  = 1'b0;
          cnt_nxt = (top == '0) ? '0 : cnt_q - ONE;
        end
      end else if (at_bot) begin
        up_nxt  = 1'b1;
        cnt_nxt = (top == '0) ? '0 : ONE;
      end else begin
        cnt_nxt = cnt_q - ONE;
      end
    end else if ((fast || is_ctc(mode_i)) && at_top) begin
      cnt_nxt = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      if (cnt_we_i)    cnt_q <= cnt_wd_i;
      else if (tick_i) cnt_q <= cnt_nxt;
      if (!ph)                      up_q <= 1'b1;
      else if (tick_i && !cnt_we_i) up_q <= up_nxt;
    end
  end

  assign cnt_o  = cnt_q;
  assign up_o   = up_q;
  assign wrap_o = tick_i && fast && at_top;
  assign ptop_o = tick_i && ph && up_q && at_top;
  assign ovf_o  = fast ? wrap_o :
                  ph   ? (tick_i && !up_q && at_bot) :
                         (tick_i && (cnt_q == '1));

  // R2: without a tick or a write the count holds
  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !cnt_we_i) |=> $stable(cnt_q));

  // R7: direction leaves rising only at TOP
  assert_turn_top_R7: assert property (@(posedge clk) disable iff (rst)
    (ph && tick_i && !cnt_we_i && up_q && !at_top) |=> up_q);
endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel import ptmr_pkg::*; #(
  parameter int CNT_W = 8,
  parameter bit IS_A  = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode_i,
  input  logic [1:0]       com_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             up_i,
  input  logic             wrap_i,
  input  logic             load_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wd_i,
  output logic [CNT_W-1:0] buf_o,
  output logic [CNT_W-1:0] act_o,
  output logic             match_o,
  output logic             lvl_o
);
  logic [CNT_W-1:0] buf_q, act_q;
  logic             lvl_q, lvl_nxt, fast, ph, pwm, inv;

  assign fast    = is_fast(mode_i);
  assign ph      = is_phase(mode_i);
  assign pwm     = fast || ph;
  assign inv     = (com_i == OUT_SET);
  assign match_o = tick_i && (cnt_i == act_q);

  always_comb begin
    lvl_nxt = lvl_q;
    if (com_i == OUT_OFF) begin
      lvl_nxt = 1'b0;
    end else if (com_i == OUT_TOG) begin
      if (pwm && !(IS_A && mode_i[2])) lvl_nxt = 1'b0;
      else if (match_o)                lvl_nxt = ~lvl_q;
    end else if (fast) begin
      if (wrap_i)       lvl_nxt = ~inv;
      else if (match_o) lvl_nxt = inv;
    end else if (ph) begin
      if (match_o) lvl_nxt = up_i ? inv : ~inv;
    end else if (match_o) begin
      lvl_nxt = inv;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      act_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      if (we_i) buf_q <= wd_i;
      if (!pwm)        act_q <= we_i ? wd_i : buf_q;
      else if (load_i) act_q <= buf_q;
      lvl_q <= lvl_nxt;
    end
  end

  assign buf_o = buf_q;
  assign act_o = act_q;
  assign lvl_o = lvl_q;

  // R5: with setting 2 in single-slope mode the output rises only at a wrap
  assert_fast_rise_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(lvl_q) && $past(fast && (com_i == OUT_CLR))) |-> $past(wrap_i));
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8 import ptmr_pkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             wave_a,
  output logic             wave_b,
  output logic             flag_ovf,
  output logic             flag_cmpa,
  output logic             flag_cmpb
);
  localparam int NCH = 2;

  logic [2:0]                mode_q, cs_q, flag_q, clr, keep;
  logic [NCH-1:0][1:0]       com_q;
  logic [NCH-1:0][CNT_W-1:0] buf_v, act_v;
  logic [NCH-1:0]            match_v, lvl_v;
  logic [CNT_W-1:0]          cnt, rdata_q;
  logic                      tick, up, wrap, ptop, ovf_evt;

  ptmr_prescale #(.LOG_MAX(10)) u_pre (
    .clk(clk), .rst(rst), .sel_i(cs_q), .tick_o(tick)
  );

  ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick), .mode_i(mode_q), .top_a_i(act_v[0]),
    .cnt_we_i(reg_we && (reg_addr == ADR_CNT)), .cnt_wd_i(reg_wdata),
    .cnt_o(cnt), .up_o(up), .wrap_o(wrap), .ptop_o(ptop), .ovf_o(ovf_evt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [2:0] ADR = (g == 0) ? ADR_CMPA : ADR_CMPB;
    ptmr_channel #(.CNT_W(CNT_W), .IS_A(g == 0)) u_ch (
      .clk(clk), .rst(rst), .mode_i(mode_q), .com_i(com_q[g]), .tick_i(tick),
      .cnt_i(cnt), .up_i(up), .wrap_i(wrap), .load_i(wrap || ptop),
      .we_i(reg_we && (reg_addr == ADR)), .wd_i(reg_wdata),
      .buf_o(buf_v[g]), .act_o(act_v[g]), .match_o(match_v[g]), .lvl_o(lvl_v[g])
    );
  end

  assign clr  = (reg_we && (reg_addr == ADR_FLAG)) ? reg_wdata[2:0] : 3'b000;
  assign keep = flag_q & ~clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      cs_q    <= '0;
      com_q   <= '0;
      flag_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (reg_we && (reg_addr == ADR_CTRL)) begin
        mode_q <= reg_wdata[2:0];
        cs_q   <= reg_wdata[5:3];
      end
      if (reg_we && (reg_addr == ADR_OUTS)) begin
        com_q[0] <= reg_wdata[1:0];
        com_q[1] <= reg_wdata[3:2];
      end
      flag_q <= keep | {match_v[1], match_v[0], ovf_evt};
      case (reg_addr)
        ADR_CTRL: rdata_q <= {{(CNT_W-6){1'b0}}, cs_q, mode_q};
        ADR_OUTS: rdata_q <= {{(CNT_W-4){1'b0}}, com_q[1], com_q[0]};
        ADR_CNT:  rdata_q <= cnt;
        ADR_CMPA: rdata_q <= buf_v[0];
        ADR_CMPB: rdata_q <= buf_v[1];
        ADR_FLAG: rdata_q <= {{(CNT_W-3){1'b0}}, flag_q};
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign wave_a    = lvl_v[0];
  assign wave_b    = lvl_v[1];
  assign flag_ovf  = flag_q[0];
  assign flag_cmpa = flag_q[1];
  assign flag_cmpb = flag_q[2];

  // R10: flags not being cleared stay set
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (keep != 3'b000) |=> ((flag_q & $past(keep)) == $past(keep)));

  // R10: an overflow event sets the flag even against a clear
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> flag_q[0]);
endmodule

// File: tb/test_pwm_timer8.sv
`timescale 1ns/1ps
module test_pwm_timer8;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd2;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       wave_a, wave_b, flag_ovf, flag_cmpa, flag_cmpb;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R11";
  bit    chk_on  = 1'b0;

  always #2.5 clk = ~clk;

  pwm_timer8 #(.CNT_W(8)) i_pwm_timer8 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wave_a(wave_a),
    .wave_b(wave_b), .flag_ovf(flag_ovf), .flag_cmpa(flag_cmpa),
    .flag_cmpb(flag_cmpb)
  );

  // behavioural reference state
  int         m_pre;
  logic [2:0] m_mode, m_cs, m_fl;
  logic [1:0] m_ca, m_cb;
  logic [7:0] m_cnt, m_ba, m_aa, m_bb, m_ab, m_rd;
  logic       m_up, m_wa, m_wb;

  function automatic logic out_nxt(input logic [1:0] com, input bit isa,
      input logic [2:0] md, input logic lvl, input bit mt, input bit wr, input bit up);
    bit fst, ph;
    fst = (md == 3) || (md == 7);
    ph  = (md == 1) || (md == 5);
    if (com == 0) return 1'b0;
    if (com == 1) begin
      if ((fst || ph) && !(isa && md[2])) return 1'b0;
      return mt ? ~lvl : lvl;
    end
    if (fst) begin
      if (wr) return com == 2;
      if (mt) return com == 3;
      return lvl;
    end
    if (ph) begin
      if (mt) return up ? (com == 3) : (com == 2);
      return lvl;
    end
    if (mt) return com == 3;
    return lvl;
  endfunction

  always @(posedge clk) begin : mdl
    bit tk, fst, ph, tpa, pwm, ma, mb, wrp, ptop, pbot, ovf, ld, wcnt;
    logic [7:0] top, ncnt, nba, naa, nbb, nab, nrd;
    logic [2:0] clr, nfl;
    logic nup, na, nb;
    if (rst) begin
      m_pre = 0; m_mode = 0; m_cs = 0; m_fl = 0; m_ca = 0; m_cb = 0;
      m_cnt = 0; m_ba = 0; m_aa = 0; m_bb = 0; m_ab = 0; m_rd = 0;
      m_up = 1; m_wa = 0; m_wb = 0;
    end else begin
      case (m_cs)
        1: tk = 1;
        2: tk = (m_pre % 8) == 7;
        3: tk = (m_pre % 64) == 63;
        4: tk = (m_pre % 256) == 255;
        5: tk = (m_pre % 1024) == 1023;
        default: tk = 0;
      endcase
      fst  = (m_mode == 3) || (m_mode == 7);
      ph   = (m_mode == 1) || (m_mode == 5);
      tpa  = (m_mode == 2) || (m_mode == 5) || (m_mode == 7);
      pwm  = fst || ph;
      top  = tpa ? m_aa : 8'hFF;
      ma   = tk && (m_cnt == m_aa);
      mb   = tk && (m_cnt == m_ab);
      wrp  = fst && tk && (m_cnt == top);
      ptop = ph && tk && m_up && (m_cnt == top);
      pbot = ph && tk && !m_up && (m_cnt == 0);
      ovf  = fst ? wrp : ph ? pbot : (tk && m_cnt == 8'hFF);
      ld   = wrp || ptop;
      ncnt = m_cnt; nup = m_up;
      if (tk) begin
        if (ph) begin
          if (m_up) begin
            if (m_cnt == top) begin nup = 0; ncnt = (top == 0) ? 8'd0 : m_cnt - 8'd1; end
            else ncnt = m_cnt + 8'd1;
          end else begin
            if (m_cnt == 0) begin nup = 1; ncnt = (top == 0) ? 8'd0 : 8'd1; end
            else ncnt = m_cnt - 8'd1;
          end
        end else if ((fst || m_mode == 2) && m_cnt == top) ncnt = 8'd0;
        else ncnt = m_cnt + 8'd1;
      end
      wcnt = reg_we && reg_addr == 2;
      if (wcnt) begin ncnt = reg_wdata; nup = m_up; end
      if (!ph) nup = 1;
      na = out_nxt(m_ca, 1, m_mode, m_wa, ma, wrp, m_up);
      nb = out_nxt(m_cb, 0, m_mode, m_wb, mb, wrp, m_up);
      nba = (reg_we && reg_addr == 3) ? reg_wdata : m_ba;
      nbb = (reg_we && reg_addr == 4) ? reg_wdata : m_bb;
      naa = pwm ? (ld ? m_ba : m_aa) : nba;
      nab = pwm ? (ld ? m_bb : m_ab) : nbb;
      clr = (reg_we && reg_addr == 5) ? reg_wdata[2:0] : 3'b000;
      nfl = (m_fl & ~clr) | {mb, ma, ovf};
      case (reg_addr)
        0: nrd = {2'b00, m_cs, m_mode};
        1: nrd = {4'b0000, m_cb, m_ca};
        2: nrd = m_cnt;
        3: nrd = m_ba;
        4: nrd = m_bb;
        5: nrd = {5'b00000, m_fl};
        default: nrd = 8'd0;
      endcase
      if (reg_we && reg_addr == 0) begin m_mode = reg_wdata[2:0]; m_cs = reg_wdata[5:3]; end
      if (reg_we && reg_addr == 1) begin m_ca = reg_wdata[1:0]; m_cb = reg_wdata[3:2]; end
      m_cnt = ncnt; m_up = nup; m_wa = na; m_wb = nb;
      m_ba = nba; m_bb = nbb; m_aa = naa; m_ab = nab; m_fl = nfl; m_rd = nrd;
      m_pre = (m_pre + 1) % 1024;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk(wave_a === m_wa, "wave_a", wave_a, m_wa);
      chk(wave_b === m_wb, "wave_b", wave_b, m_wb);
      chk(flag_ovf === m_fl[0], "flag_ovf", flag_ovf, m_fl[0]);
      chk(flag_cmpa === m_fl[1], "flag_cmpa", flag_cmpa, m_fl[1]);
      chk(flag_cmpb === m_fl[2], "flag_cmpb", flag_cmpb, m_fl[2]);
      chk(reg_rdata === m_rd, "reg_rdata", reg_rdata, m_rd);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'd2;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R11 watchdog: actual 200000 cycles expected fewer");
    finish_run();
  end

  initial begin
    int a_hi, b_hi;
    logic [7:0] snap;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk_on = 1'b1;
    // R11 reset state
    cur_req = "R11";
    run(1);
    chk(wave_a === 0 && wave_b === 0, "reset waves", {wave_a, wave_b}, 0);
    chk({flag_ovf, flag_cmpa, flag_cmpb} === 3'b000, "reset flags",
        {flag_ovf, flag_cmpa, flag_cmpb}, 0);
    chk(reg_rdata === 8'd0, "reset count", reg_rdata, 0);

    // R3 normal counting, R9 compare flags
    cur_req = "R3";
    wr(3, 30); wr(4, 200); wr(1, 8'h0D); wr(0, 8'h08);
    run(600);
    chk(flag_ovf === 1'b1, "R3 overflow after wrap", flag_ovf, 1);
    cur_req = "R9";
    chk(flag_cmpb === 1'b1, "R9 compare B flag", flag_cmpb, 1);

    // R2 prescaler and stop
    cur_req = "R2";
    wr(5, 7); wr(0, 8'h10); run(500);
    wr(0, 8'h00); run(2);
    snap = reg_rdata; run(50);
    chk(reg_rdata === snap, "R2 stopped count holds", reg_rdata, snap);
    wr(0, 8'h18); run(600);
    wr(0, 8'h20); run(1200);
    wr(0, 8'h28); run(3000);
    wr(0, 8'h30); run(100);

    // R4 clear-on-compare, missed match
    cur_req = "R4";
    wr(3, 20); wr(4, 5); wr(1, 8'h09); wr(0, 8'h0A);
    run(300);
    wr(3, 200); wr(2, 100); wr(3, 50); wr(5, 7);
    run(100);
    chk(flag_cmpa === 1'b0, "R4 match missed below count", flag_cmpa, 0);
    run(200);
    chk(flag_cmpa === 1'b1, "R4 match after wrap", flag_cmpa, 1);

    // R5 single-slope PWM with buffered compare
    cur_req = "R5";
    wr(3, 100); wr(4, 40); wr(1, 8'h0E); wr(0, 8'h0B);
    run(600);
    wr(3, 200); run(600);
    wr(3, 60); wr(4, 30); wr(1, 8'h09); wr(0, 8'h0F);
    run(400);

    // R6 extreme compare values
    cur_req = "R6";
    wr(0, 8'h0B); wr(3, 0); wr(4, 255); wr(1, 8'h0A);
    run(600);
    a_hi = 0; b_hi = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (wave_a) a_hi++;
      if (wave_b) b_hi++;
    end
    chk(a_hi == 1, "R6 spike width", a_hi, 1);
    chk(b_hi == 256, "R6 constant level", b_hi, 256);

    // R7 dual-slope PWM
    cur_req = "R7";
    wr(3, 80); wr(4, 200); wr(1, 8'h0E); wr(0, 8'h09);
    run(1100);
    wr(4, 100); run(600);
    wr(3, 50); wr(4, 20); wr(1, 8'h05); wr(0, 8'h0D);
    run(400);

    // R8 toggle restrictions in PWM modes
    cur_req = "R8";
    chk(wave_b === 1'b0, "R8 B toggle off in PWM", wave_b, 0);
    wr(0, 8'h0B); wr(1, 8'h05); run(300);
    chk(wave_a === 1'b0, "R8 A toggle off without mode bit 2", wave_a, 0);
    wr(0, 8'h0F); run(300);

    // R1 reserved modes and control readback
    cur_req = "R1";
    wr(0, 8'h0C); wr(1, 8'h0D); run(600);
    wr(0, 8'h0E); run(300);
    @(negedge clk); reg_addr = 3'd0;
    @(negedge clk);
    chk(reg_rdata === 8'h0E, "R1 control readback", reg_rdata, 8'h0E);
    reg_addr = 3'd2;

    // R10 set beats clear, write-one clear
    cur_req = "R10";
    wr(0, 8'h08);
    @(negedge clk); reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 8'hFF;
    @(negedge clk); reg_addr = 3'd5; reg_wdata = 8'h07;
    @(negedge clk); reg_we = 1'b0; reg_addr = 3'd2;
    chk(flag_ovf === 1'b1, "R10 set wins over clear", flag_ovf, 1);
    wr(5, 8'h00); run(2);
    chk(flag_ovf === 1'b1, "R10 zero write no effect", flag_ovf, 1);
    wr(5, 8'h01);
    chk(flag_ovf === 1'b0, "R10 write one clears", flag_ovf, 0);

    // R11 count write and read latency
    cur_req = "R11";
    wr(2, 77); run(1);
    chk(reg_rdata === 8'd77, "R11 count write readback", reg_rdata, 77);
    run(20);

    chk_on = 1'b0;
    finish_run();
  end
endmodule